// File: doc/BRIEF.md
# Pipelined GF(2^m) Array Multiplier

This block multiplies two elements of the binary extension field GF(2^M) written in polynomial basis. It returns C = A·B reduced modulo the field polynomial x^M + poly(x). The datapath is a grid of M rows by M columns of identical one-bit cells with a register stage after every row, so a new operand pair can be accepted on every clock.

Row i does two things in the same cycle, both from the same registered operand multiple x^i·B mod P. It adds a_i times that multiple into the running column sums, and it shifts and reduces the multiple to form x^(i+1)·B mod P for the next row. Because the two updates run side by side, a row's logic is one AND gate and one XOR gate in front of a flip-flop. Each coefficient a_i is delayed by i cycles, so it reaches row i together with its own operation.

The block is meant for streams of field multiplications, such as exponentiation ladders or syndrome work, where the control logic keeps one product in flight per clock and accepts the fixed M-cycle delay.

Top module: `gf_array_mul`

## Requirements
- R1: When out_valid is high, c_out equals a_in·b_in mod (x^M + poly) for the pair accepted M cycles earlier. Bit j of every operand and of poly is the coefficient of x^j. The x^M term is implied, poly[0] is 1, and poly is held constant while any operation is in flight.
- R2: out_valid goes high exactly M clock cycles after the cycle in which in_valid was sampled high, and c_out in that cycle carries that pair's product.
- R3: A new operand pair can be accepted on every clock. Back-to-back operations come out in order on consecutive cycles and do not disturb one another.
- R4: out_valid is low in every cycle whose input slot M cycles earlier had in_valid low, so gaps in the input stream reappear unchanged at the output.
- R5: c_out is all zeros in every cycle in which out_valid is low.
- R6: The reset is synchronous and active low. A clock edge with rst_n low drives out_valid and c_out to zero and discards every operation in flight, so none of them appears after reset is released.
- R7: Corner operands. A zero operand gives a zero product. The operand 1 returns the other operand. x times x^(M-1) returns poly, which exercises the reduction.
- R8: A new poly value, applied while the pipeline is empty, is used for every operation accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operand pair is presented this cycle |
| a_in | input | M | Multiplier A, bit j = coefficient of x^j |
| b_in | input | M | Multiplicand B, bit j = coefficient of x^j |
| poly | input | M | Field polynomial below x^M, bit j = coefficient of x^j |
| out_valid | output | 1 | c_out holds a finished product |
| c_out | output | M | Product A·B mod P, zero when out_valid is low |

## Verification
In a back-to-back stream the block accepts a new pair and delivers an older product in the same cycle. The bench provokes this with long runs of consecutive valid inputs and with runs broken by random gaps. Every result is compared, in order, against a queue of products computed in the bench, and each entry records the cycle in which its result is due. Any slip in the skew of the A coefficients, or in the alignment of valid with data, shows up as a product from the wrong pair or as a missing or extra out_valid. A reset issued while products are in flight is judged the same way: nothing queued before the reset may come out.

// File: rtl/gf_array_pkg.sv
// Package gf_array_pkg
// Shared constants and a behavioural field product used by the checker.
// Assumes field widths of at most GF_MAX_M bits.
package gf_array_pkg;

    localparam int unsigned DEF_M    = 8;
    localparam int unsigned GF_MAX_M = 64;

    typedef logic [GF_MAX_M-1:0] gf_word_t;

    // Shift-and-add product, Horner order from the top coefficient of a.
    function automatic gf_word_t gf_ref_mul(gf_word_t a, gf_word_t b, gf_word_t p, int unsigned m);
        gf_word_t r;
        gf_word_t mask;
        logic     top;
        mask = (m >= GF_MAX_M) ? '1 : ((gf_word_t'(1) << m) - gf_word_t'(1));
        r    = '0;
        for (int i = int'(m) - 1; i >= 0; i--) begin
            top = r[6'(m - 1)];
            r   = (r << 1) & mask;
            if (top)       r = r ^ (p & mask);
            if (a[6'(i)])  r = r ^ (b & mask);
        end
        return r;
    endfunction

endpackage

// File: rtl/gf_skew.sv
// Module gf_skew
// Delays bit i of the multiplier by i clock cycles, so that coefficient a_i
// arrives at row i together with the operation it belongs to.
// Assumes M >= 2. Bit 0 passes straight through.
module gf_skew #(
    parameter int unsigned M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [M-1:0] a_in,
    output logic [M-1:0] a_sk
);

    assign a_sk[0] = a_in[0];

    for (genvar i = 1; i < M; i++) begin : g_lane
        logic [i-1:0] sr;

        // Delay line of depth i for coefficient i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sr <= '0;
            end else begin
                sr[0] <= a_in[i];
                for (int d = 1; d < i; d++) begin
                    sr[d] <= sr[d-1];
                end
            end
        end

        assign a_sk[i] = sr[i-1];
    end

endmodule

// File: rtl/gf_cell.sv
// Module gf_cell
// One column cell of a row: adds a_i·b(i,j) into column sum j.
// Purely combinational; the register sits in gf_row.
module gf_cell (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_bit,
    output logic c_nx
);

    // Partial product folded into the column sum.
    always_comb c_nx = c_bit ^ (a_bit & b_bit);

endmodule

// File: rtl/gf_row.sv
// Module gf_row
// Accumulation slice of one array row: M cells plus the column-sum and
// valid registers. Sums are cleared for bubbles so idle slots carry zeros.
// Assumes b_row and c_in come from the previous stage's registers.
module gf_row #(
    parameter int unsigned M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_in,
    input  logic         a_bit,
    input  logic [M-1:0] b_row,
    input  logic [M-1:0] c_in,
    output logic [M-1:0] c_q,
    output logic         vld_q
);

    logic [M-1:0] c_nx;

    for (genvar j = 0; j < M; j++) begin : g_col
        gf_cell u_cell (
            .a_bit (a_bit),
            .b_bit (b_row[j]),
            .c_bit (c_in[j]),
            .c_nx  (c_nx[j])
        );
    end

    // Register the column sums and the valid flag of this stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q   <= '0;
            vld_q <= 1'b0;
        end else begin
            c_q   <= vld_in ? c_nx : '0;
            vld_q <= vld_in;
        end
    end

endmodule

// File: rtl/gf_reduce.sv
// Module gf_reduce
// Reduction slice of one array row: forms x·b mod P from the current multiple
// and registers it for the next row. It runs beside gf_row from the same input.
// Assumes poly is the field polynomial without its x^M term, held static.
module gf_reduce #(
    parameter int unsigned M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [M-1:0] b_row,
    input  logic [M-1:0] poly,
    output logic [M-1:0] b_q
);

    logic [M-1:0] b_nx;
    logic         b_top;

    assign b_top = b_row[M-1];

    for (genvar j = 0; j < M; j++) begin : g_bit
        if (j == 0) begin : g_low
            // Lowest coefficient only receives the feedback term.
            always_comb b_nx[j] = b_top & poly[j];
        end else begin : g_mid
            // Shifted coefficient plus feedback term.
            always_comb b_nx[j] = b_row[j-1] ^ (b_top & poly[j]);
        end
    end

    // Register the next multiple for the following row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_nx;
        end
    end

endmodule

// File: rtl/gf_array_mul.sv
// Module gf_array_mul
// Fully pipelined M x M GF(2^M) multiplier. Row k adds a_k·(x^k·B mod P) into
// the column sums and, in parallel, produces x^(k+1)·B mod P for row k+1.
// A result emerges M cycles after its operands; one pair per clock.
// Assumes M >= 2, poly[0] = 1 and poly constant while operations are in flight.
module gf_array_mul #(
    parameter int unsigned M = gf_array_pkg::DEF_M
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    input  logic [M-1:0] poly,
    output logic         out_valid,
    output logic [M-1:0] c_out
);

    logic [M-1:0] a_sk;
    logic [M-1:0] brow [0:M-1];
    logic [M-1:0] acc  [0:M];
    logic         vld  [0:M];

    gf_skew #(.M(M)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .a_in  (a_in),
        .a_sk  (a_sk)
    );

    assign brow[0] = b_in;
    assign acc[0]  = '0;
    assign vld[0]  = in_valid;

    for (genvar k = 0; k < M; k++) begin : g_row
        gf_row #(.M(M)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_in (vld[k]),
            .a_bit  (a_sk[k]),
            .b_row  (brow[k]),
            .c_in   (acc[k]),
            .c_q    (acc[k+1]),
            .vld_q  (vld[k+1])
        );
        if (k < M - 1) begin : g_red
            gf_reduce #(.M(M)) u_red (
                .clk   (clk),
                .rst_n (rst_n),
                .b_row (brow[k]),
                .poly  (poly),
                .b_q   (brow[k+1])
            );
        end
    end

    assign c_out     = acc[M];
    assign out_valid = vld[M];

endmodule

// File: rtl/gf_array_mul_chk.sv
// Module gf_array_mul_chk
// Checker bound to gf_array_mul. It keeps a shadow delay line of valid flags
// and behavioural products and compares the ports against it.
module gf_array_mul_chk #(
    parameter int unsigned M = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [M-1:0] a_in,
    input logic [M-1:0] b_in,
    input logic [M-1:0] poly,
    input logic         out_valid,
    input logic [M-1:0] c_out
);

    logic [M-1:0]                 sh_vld;
    logic [M-1:0]                 sh_prod [0:M-1];
    gf_array_pkg::gf_word_t       ref_full;

    // Behavioural product of the pair at the inputs.
    always_comb ref_full = gf_array_pkg::gf_ref_mul(64'(a_in), 64'(b_in), 64'(poly), M);

    // Shadow pipeline of valid flags and expected products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_vld <= '0;
        end else begin
            sh_vld     <= {sh_vld[M-2:0], in_valid};
            sh_prod[0] <= ref_full[M-1:0];
            for (int s = 1; s < M; s++) begin
                sh_prod[s] <= sh_prod[s-1];
            end
        end
    end

    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> c_out == sh_prod[M-1]);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_vld[M-1] |-> out_valid);

    p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_vld[M-1] |-> !out_valid);

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> c_out == '0);

    p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && c_out == '0));

endmodule

bind gf_array_mul gf_array_mul_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .poly      (poly),
    .out_valid (out_valid),
    .c_out     (c_out)
);

// File: tb/test_gf_array_mul.sv
`timescale 1ns/1ps
module test_gf_array_mul;

    localparam int M = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [M-1:0] a_in = '0;
    logic [M-1:0] b_in = '0;
    logic [M-1:0] poly = 8'h1B;
    logic         out_valid;
    logic [M-1:0] c_out;

    typedef struct {
        int           due;
        logic [M-1:0] val;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_err = 0;
    int   cyc = 0;
    bit   finished = 0;

    gf_array_mul #(.M(M)) i_gf_array_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .poly      (poly),
        .out_valid (out_valid),
        .c_out     (c_out)
    );

    always #4 clk = ~clk;

    function automatic logic [M-1:0] xt(logic [M-1:0] v, logic [M-1:0] p);
        return v[M-1] ? ((v << 1) ^ p) : (v << 1);
    endfunction

    // Sum of a_i times successive x-multiples of b.
    function automatic logic [M-1:0] ref_mul(logic [M-1:0] a, logic [M-1:0] b, logic [M-1:0] p);
        logic [M-1:0] t = b;
        logic [M-1:0] r = '0;
        for (int i = 0; i < M; i++) begin
            if (a[i]) r = r ^ t;
            t = xt(t, p);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, expv);
        end
    endtask

    // Compare outputs against the queue head; vtag names the valid rule.
    task automatic observe(input string vtag);
        bit due_now;
        due_now = (q.size() > 0) && (q[0].due == cyc);
        check(out_valid == due_now, vtag, M'(out_valid), M'(due_now));
        if (due_now && out_valid) begin
            check(c_out == q[0].val, "R1", c_out, q[0].val);
        end
        if (due_now) void'(q.pop_front());
        if (!out_valid) check(c_out == '0, "R5", c_out, '0);
    endtask

    task automatic step(input bit v, input logic [M-1:0] a, input logic [M-1:0] b, input string vtag);
        @(negedge clk);
        cyc++;
        observe(vtag);
        in_valid = v;
        a_in     = a;
        b_in     = b;
        if (v) q.push_back('{cyc + M, ref_mul(a, b, poly)});
    endtask

    task automatic reset_phase(input int n);
        @(negedge clk);
        cyc++;
        observe("R2");
        rst_n    = 1'b0;
        in_valid = 1'b0;
        q.delete();
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cyc++;
            check(out_valid == 1'b0, "R6", M'(out_valid), '0);
            check(c_out == '0, "R6", c_out, '0);
        end
        rst_n = 1'b1;
    endtask

    task automatic drain();
        for (int k = 0; k < M + 2; k++) step(1'b0, '0, '0, "R4");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        reset_phase(3);

        // R7 directed corners with poly x^8+x^4+x^3+x+1.
        step(1'b1, 8'h00, 8'hFF, "R2");
        step(1'b1, 8'hA5, 8'h00, "R2");
        step(1'b1, 8'h01, 8'h6C, "R2");
        step(1'b1, 8'hD3, 8'h01, "R2");
        step(1'b1, 8'h02, 8'h80, "R2");
        step(1'b1, 8'hFF, 8'hFF, "R2");
        drain();
        check(ref_mul(8'h02, 8'h80, poly) == poly, "R7", ref_mul(8'h02, 8'h80, poly), poly);

        // R3 back-to-back random stream.
        for (int k = 0; k < 300; k++) step(1'b1, M'($urandom), M'($urandom), "R3");
        // R4 stream with random gaps.
        for (int k = 0; k < 300; k++) step(1'($urandom), M'($urandom), M'($urandom), "R4");
        drain();

        // R8 new polynomial while empty: x^8+x^4+x^3+x^2+1.
        poly = 8'h1D;
        step(1'b1, 8'h02, 8'h80, "R8");
        for (int k = 0; k < 200; k++) step(1'b1, M'($urandom), M'($urandom), "R8");
        drain();

        // R6 reset with operations in flight; none may reappear.
        for (int k = 0; k < 5; k++) step(1'b1, M'($urandom) | 8'h01, 8'hFF, "R2");
        reset_phase(2);
        for (int k = 0; k < M + 3; k++) step(1'b0, '0, '0, "R6");

        for (int k = 0; k < 100; k++) step(1'b1, M'($urandom), M'($urandom), "R3");
        drain();

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule